// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt requests, holds them in a request register and filters them through a mask register. It picks a winner by fixed priority, where input 0 ranks highest, and raises an interrupt line towards a processor. When the processor acknowledges, the block moves the winning request into an in-service register. Its vector output gives the programmed base plus the winning input number. Software later retires the in-service level with an end-of-interrupt command. The command can name the level explicitly, or it can leave the level unnamed, in which case the highest-priority level in service is retired.

Software reaches the block through a byte-wide write/read port with one select bit. Select 0 is the command port and select 1 is the data port. After reset the block must first receive an initialization sequence of two to four bytes:

- The first byte sets the trigger mode and how many further bytes follow.
- The second byte is the vector base.

Once the sequence is complete, the data port holds the mask. The command port takes end-of-interrupt commands and read-select commands. The read-select value chooses whether a command-port read shows the request register or the in-service register. Requests can be latched on rising edges or sampled as levels.

Top module: `irq8_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are zero. Command-port reads return the request register. `int_out` is low. The block waits for the first initialization byte on the command port, and data-port writes in that state are ignored.
- R2: The first byte (command port) encodes its fields in these bits:
  - bit1 = single mode
  - bit0 = fourth byte needed
  - bit3 = level mode

  The next data-port byte is the vector base. If bit1 is clear, one further data-port byte is taken. If bit0 is set, one more data-port byte is then taken. After that the block is ready. `int_out` stays low until ready.
- R3: While `int_out` is high, `vec_out` equals the vector base plus the index (0..7) of the winning input, modulo 256.
- R4: An input is eligible when its request bit is 1 and its mask bit is 0. The lowest-index eligible input wins.
- R5: When `int_ack` is high in a cycle where `int_out` is high, the winner's request bit is cleared and its in-service bit is set. When `int_ack` is high while `int_out` is low, it has no effect.
- R6: `int_out` is high only when the winner's index is lower than the index of every set in-service bit. A set in-service bit therefore blocks inputs of equal or higher index.
- R7: A command byte of the form 011_00_lll (specific end-of-interrupt) clears in-service bit lll.
- R8: The command byte 001_00_xxx (non-specific end-of-interrupt) clears only the lowest-index in-service bit that is set.
- R9: A command byte with bits[4:3]=01 stores bits[1:0] as the read select. Command-port reads then return:
  - select 10: the request register
  - select 11: the in-service register
  - any other select: zero
- R10: When ready, a data-port write loads the mask register, and a data-port read returns it.
- R11: In edge mode a request bit is set by a 0-to-1 transition of its input. An input held high after acknowledge does not set the bit again. In level mode the bit is set in every cycle its input is high.
- R12: When ready, a command byte with bit4 set, or with bits[4:3]=00 that is neither end-of-interrupt form, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | 0 = command port, 1 = data port |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for the selected port (combinational) |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to processor |
| int_ack | input | 1 | Acknowledge strobe |
| vec_out | output | 8 | Vector of the current winner |

## Verification
An error in the in-service register shows up at the ports in two ways. `int_out` is held low when it should be high, or it is raised for a blocked level. Either effect is visible in the cycle after the faulty acknowledge or end-of-interrupt command, and it can also be read back through the in-service readback select. A wrong state in the initialization sequence shows as `int_out` staying low after the final byte, or as the base or mask landing in the wrong register. That error appears in the vector or in the data-port read straight after the sequence. Trigger-mode faults show one cycle after an acknowledge, when the request register reappears or fails to reappear while its input is held high.

// File: rtl/irq8_pkg.sv
package irq8_pkg;

   typedef enum logic [2:0] {
      ST_W1  = 3'd0,
      ST_W2  = 3'd1,
      ST_W3  = 3'd2,
      ST_W4  = 3'd3,
      ST_RDY = 3'd4
   } init_st_t;

   // Bit positions inside the first initialization byte
   localparam int W1_NEED4  = 0;
   localparam int W1_SINGLE = 1;
   localparam int W1_LEVEL  = 3;

   // Command byte forms (bits [7:5] of a bits[4:3]=00 command)
   localparam logic [2:0] CMD_EOI_SPEC = 3'b011;
   localparam logic [2:0] CMD_EOI_NS   = 3'b001;

   localparam logic [1:0] RSEL_IRR = 2'b10;
   localparam logic [1:0] RSEL_ISR = 2'b11;

endpackage

// File: rtl/irq8_pick.sv
module irq8_pick #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq8_cfg.sv
module irq8_cfg
   import irq8_pkg::*;
#(
   parameter int DW   = 8,
   parameter int N_IN = 8,
   parameter int IW   = $clog2(N_IN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            port_sel,
   input  logic            wr_en,
   input  logic [DW-1:0]   wr_data,
   output logic            ready,
   output logic [DW-1:0]   vec_base,
   output logic            level_mode,
   output logic [N_IN-1:0] mask,
   output logic [1:0]      rd_sel,
   output logic            eoi_sp,
   output logic            eoi_ns,
   output logic [IW-1:0]   eoi_lvl
);
   init_st_t      st;
   logic [DW-1:0] w1;
   logic          cmd_wr, dat_wr, is_rsel, is_ocw;

   assign cmd_wr  = wr_en & ~port_sel;
   assign dat_wr  = wr_en &  port_sel;
   assign ready   = (st == ST_RDY);
   assign is_rsel = (wr_data[4:3] == 2'b01);
   assign is_ocw  = (wr_data[4:3] == 2'b00);

   assign eoi_sp  = ready & cmd_wr & is_ocw & (wr_data[7:5] == CMD_EOI_SPEC);
   assign eoi_ns  = ready & cmd_wr & is_ocw & (wr_data[7:5] == CMD_EOI_NS);
   assign eoi_lvl = wr_data[IW-1:0];
   assign level_mode = w1[W1_LEVEL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_W1;
         w1       <= '0;
         vec_base <= '0;
         mask     <= '0;
         rd_sel   <= RSEL_IRR;
      end else begin
         unique case (st)
            ST_W1: if (cmd_wr) begin
               w1 <= wr_data;
               st <= ST_W2;
            end
            ST_W2: if (dat_wr) begin
               vec_base <= wr_data;
               if (!w1[W1_SINGLE])    st <= ST_W3;
               else if (w1[W1_NEED4]) st <= ST_W4;
               else                   st <= ST_RDY;
            end
            ST_W3: if (dat_wr) begin
               st <= w1[W1_NEED4] ? ST_W4 : ST_RDY;
            end
            ST_W4: if (dat_wr) st <= ST_RDY;
            ST_RDY: begin
               if (dat_wr) mask <= wr_data[N_IN-1:0];
               if (cmd_wr && is_rsel) rd_sel <= wr_data[1:0];
            end
            default: st <= ST_W1;
         endcase
      end
   end
endmodule

// File: rtl/irq8_svc.sv
module irq8_svc #(
   parameter int N_IN = 8,
   parameter int IW   = $clog2(N_IN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] req_in,
   input  logic            level_mode,
   input  logic            ack_go,
   input  logic [IW-1:0]   ack_idx,
   input  logic            eoi_sp,
   input  logic            eoi_ns,
   input  logic [IW-1:0]   eoi_lvl,
   input  logic            isr_any,
   input  logic [IW-1:0]   isr_low_idx,
   output logic [N_IN-1:0] irr,
   output logic [N_IN-1:0] isr
);
   logic [N_IN-1:0] req_q, new_req, ack_mask, clr_mask;

   for (genvar g = 0; g < N_IN; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q[g] <= 1'b0;
         else        req_q[g] <= req_in[g];
      end
      assign new_req[g]  = req_in[g] & (level_mode | ~req_q[g]);
      assign ack_mask[g] = ack_go & (ack_idx == IW'(g));
      assign clr_mask[g] = (eoi_sp & (eoi_lvl == IW'(g)))
                         | (eoi_ns & isr_any & (isr_low_idx == IW'(g)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr <= '0;
         isr <= '0;
      end else begin
         irr <= (irr | new_req) & ~ack_mask;
         isr <= (isr & ~clr_mask) | ack_mask;
      end
   end
endmodule

// File: rtl/irq8_ctrl.sv
module irq8_ctrl #(
   parameter int DW   = 8,
   parameter int N_IN = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          port_sel,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   input  logic [N_IN-1:0] irq_in,
   output logic          int_out,
   input  logic          int_ack,
   output logic [DW-1:0] vec_out
);
   import irq8_pkg::*;
   localparam int IW = $clog2(N_IN);

   if (N_IN > DW || N_IN < 2 || (1 << IW) != N_IN || DW != 8) begin : g_bad_cfg
      $error("irq8_ctrl: N_IN must be a power of two no wider than DW, DW must be 8");
   end

   logic            ready, level_mode, eoi_sp, eoi_ns;
   logic [DW-1:0]   vec_base;
   logic [N_IN-1:0] mask, irr, isr, elig;
   logic [1:0]      rd_sel;
   logic [IW-1:0]   eoi_lvl, win_idx, isr_low_idx;
   logic            win_any, isr_any, ack_go;

   irq8_cfg #(.DW(DW), .N_IN(N_IN), .IW(IW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
      .wr_data(wr_data), .ready(ready), .vec_base(vec_base),
      .level_mode(level_mode), .mask(mask), .rd_sel(rd_sel),
      .eoi_sp(eoi_sp), .eoi_ns(eoi_ns), .eoi_lvl(eoi_lvl)
   );

   assign elig = irr & ~mask;

   irq8_pick #(.N(N_IN), .IW(IW)) u_pick_req (
      .vec(elig), .any(win_any), .idx(win_idx)
   );

   irq8_pick #(.N(N_IN), .IW(IW)) u_pick_isr (
      .vec(isr), .any(isr_any), .idx(isr_low_idx)
   );

   assign int_out = ready & win_any & (~isr_any | (win_idx < isr_low_idx));
   assign ack_go  = int_ack & int_out;
   assign vec_out = vec_base + DW'(win_idx);

   irq8_svc #(.N_IN(N_IN), .IW(IW)) u_svc (
      .clk(clk), .rst_n(rst_n), .req_in(irq_in), .level_mode(level_mode),
      .ack_go(ack_go), .ack_idx(win_idx), .eoi_sp(eoi_sp), .eoi_ns(eoi_ns),
      .eoi_lvl(eoi_lvl), .isr_any(isr_any), .isr_low_idx(isr_low_idx),
      .irr(irr), .isr(isr)
   );

   always_comb begin
      if (port_sel)                rd_data = DW'(mask);
      else if (rd_sel == RSEL_IRR) rd_data = DW'(irr);
      else if (rd_sel == RSEL_ISR) rd_data = DW'(isr);
      else                         rd_data = '0;
   end
endmodule

// File: rtl/irq8_ctrl_chk.sv
module irq8_ctrl_chk #(
   parameter int N_IN = 8,
   parameter int IW   = $clog2(N_IN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            int_out,
   input logic            int_ack,
   input logic            ready,
   input logic [N_IN-1:0] irr,
   input logic [N_IN-1:0] isr,
   input logic [N_IN-1:0] mask,
   input logic [IW-1:0]   win_idx,
   input logic            eoi_sp,
   input logic            eoi_ns
);
   AST_NO_INT_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !int_out); // R2
   AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (irr[win_idx] && !mask[win_idx] && !isr[win_idx])); // R4
   AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out) |=> isr[$past(win_idx)]); // R5
   AST_ACK_CLEARS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out) |=> !irr[$past(win_idx)]); // R5
   AST_NS_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_ns && !(int_ack && int_out)) |=>
         ($countones(isr) == $countones($past(isr)) - (($past(isr) != '0) ? 1 : 0))); // R8
   AST_ISR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!(int_ack && int_out) && !eoi_sp && !eoi_ns) |=> $stable(isr)); // R12
endmodule

bind irq8_ctrl irq8_ctrl_chk #(.N_IN(N_IN), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .int_out(int_out), .int_ack(int_ack),
   .ready(ready), .irr(irr), .isr(isr), .mask(mask), .win_idx(win_idx),
   .eoi_sp(eoi_sp), .eoi_ns(eoi_ns)
);

// File: tb/irq8_ctrl_tb.sv
module irq8_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] irq_in = '0;
   logic       int_out;
   logic       int_ack = 1'b0;
   logic [7:0] vec_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq8_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in),
      .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; int_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      port_sel = sel; wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rd(input logic sel, output logic [7:0] d);
      port_sel = sel;
      #1;
      d = rd_data;
   endtask

   task automatic ack();
      @(negedge clk);
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
      #1;
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk);
      irq_in = v;
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      rd(1'b0, d); chk("R1 irr read after reset", d, 8'h00);
      chk("R1 int_out after reset", int_out, 0);
      wr(1'b1, 8'hFF);                   // ignored: still waiting for word 1
      set_irq(8'h04);
      chk("R2 no int before ready", int_out, 0);
      rd(1'b0, d); chk("R1 irr latches before ready", d, 8'h04);
      wr(1'b0, 8'h13); wr(1'b1, 8'h30); wr(1'b1, 8'h01);
      rd(1'b1, d); chk("R1 mask zero after early data write", d, 8'h00);
      chk("R3 vector after init", vec_out, 8'h32);
   endtask

   task automatic t_init_seq();
      do_reset();
      wr(1'b0, 8'h11);                   // not single, fourth byte needed
      wr(1'b1, 8'h50);
      set_irq(8'h01);
      chk("R2 not ready awaiting third byte", int_out, 0);
      wr(1'b1, 8'h00);
      chk("R2 not ready awaiting fourth byte", int_out, 0);
      wr(1'b1, 8'h01);
      chk("R2 ready after fourth byte", int_out, 1);
      chk("R3 vector base 0x50 pin 0", vec_out, 8'h50);
   endtask

   task automatic t_service();
      logic [7:0] d;
      do_reset();
      wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h01);
      ack();                             // int_out low: no effect
      wr(1'b0, 8'h0B); rd(1'b0, d); chk("R5 ack ignored when idle", d, 8'h00);
      wr(1'b0, 8'h0A);
      set_irq(8'h28);
      chk("R4 int_out with pins 3,5", int_out, 1);
      chk("R3 R4 lowest pin wins", vec_out, 8'h23);
      rd(1'b0, d); chk("R9 irr readback", d, 8'h28);
      ack();
      rd(1'b0, d); chk("R5 irr bit cleared on ack", d, 8'h20);
      chk("R6 pin 5 blocked by in-service 3", int_out, 0);
      wr(1'b0, 8'h0B); rd(1'b0, d); chk("R5 R9 isr readback", d, 8'h08);
      wr(1'b0, 8'h20);
      rd(1'b0, d); chk("R8 nonspecific eoi", d, 8'h00);
      chk("R3 vector for pin 5", vec_out, 8'h25);
      ack();
      wr(1'b0, 8'h0A); rd(1'b0, d); chk("R11 edge: held inputs not re-latched", d, 8'h00);
      set_irq(8'h2A);
      chk("R6 higher pin overrides in-service", int_out, 1);
      chk("R3 vector for pin 1", vec_out, 8'h21);
      ack();
      wr(1'b0, 8'h0B); rd(1'b0, d); chk("R5 isr holds 1 and 5", d, 8'h22);
      wr(1'b0, 8'hE0);                   // rotate form: ignored
      wr(1'b0, 8'h10);                   // bit4 set: ignored
      wr(1'b0, 8'h40);                   // no EOI bit: ignored
      rd(1'b0, d); chk("R12 invalid commands ignored", d, 8'h22);
      wr(1'b0, 8'h20);
      rd(1'b0, d); chk("R8 clears only lowest bit", d, 8'h20);
      wr(1'b0, 8'h65);
      rd(1'b0, d); chk("R7 specific eoi level 5", d, 8'h00);
      wr(1'b0, 8'h08);
      rd(1'b0, d); chk("R9 other select reads zero", d, 8'h00);
      wr(1'b0, 8'h0A);
      set_irq(8'h00);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      wr(1'b1, 8'h01);
      rd(1'b1, d); chk("R10 mask readback", d, 8'h01);
      set_irq(8'h05);
      chk("R4 masked pin 0 skipped", vec_out, 8'h22);
      wr(1'b1, 8'h00);
      chk("R10 unmask pin 0", vec_out, 8'h20);
      wr(1'b1, 8'h05);
      chk("R4 all requests masked", int_out, 0);
      wr(1'b1, 8'h00);
      set_irq(8'h00);
   endtask

   task automatic t_level();
      logic [7:0] d;
      do_reset();
      wr(1'b0, 8'h1A); wr(1'b1, 8'h40); // level, single, no fourth byte
      set_irq(8'h40);
      chk("R3 level vector pin 6", vec_out, 8'h46);
      ack();
      @(negedge clk); #1;
      rd(1'b0, d); chk("R11 level re-latches held input", d, 8'h40);
      chk("R6 equal level blocked", int_out, 0);
      set_irq(8'h00);
   endtask

   initial begin
      t_reset();
      t_init_seq();
      t_service();
      t_mask();
      t_level();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule